// File: doc/BRIEF.md
# Register Access Validator and Dispatcher

This block stands between a register bus and a bank of interrupt-control registers. Each request carries a byte offset, a length in bytes, a read/write flag and, for writes, little-endian bus data. The block compares the offset against a parameterized table of register regions. Each region entry gives a base offset, a size in bytes, a mask of allowed access widths and a number of state bits held per interrupt. From these the block decides whether the access is legal.

One clock after a request, the block raises a response flag. When the access is legal, it also pulses a strobe to the register bank. The strobe carries the region index, the first interrupt number touched by the access, and the write data converted to the host's byte order. Read data from the bank is converted back to bus byte order in that same response cycle. An illegal read returns zero. An illegal write reaches no register.

The host byte order is a parameter (big-endian by default), so the byte reversal can be seen at the ports. The number of implemented shared interrupts is a quasi-static input. It is added to a fixed block of 32 private interrupts to give the interrupt limit.

Top module: `reg_gate`

## Requirements
- R1: An offset belongs to a region when it is at least the region base and strictly below base plus size. An offset inside no region is rejected.
- R2: When regions overlap, the region with the lowest index is selected. Its checks decide acceptance even if a higher region would allow the access.
- R3: Only lengths of 1, 4 and 8 bytes are recognised, mapped to allowed-width mask bits 0, 1 and 2. Any other length, or a length whose bit is clear in the selected region's mask, is rejected.
- R4: An access whose offset is not a multiple of its length is rejected.
- R5: For a region with nonzero bits-per-interrupt B, the interrupt number is ((offset - base) * 8) / B. The access is rejected unless that number is below 32 + nrShared.
- R6: A region with B = 0 skips the interrupt-range check and reports interrupt number 0.
- R7: With the default big-endian host, accepted write data and returned read data keep only the low `len` bytes, in reversed byte order. All higher bytes are zero.
- R8: For every rejected or unmatched read, rspRdata is all zeros in its response cycle.
- R9: A rejected write produces no bankStb pulse.
- R10: For each request, rspValid is high for exactly the next cycle. For an accepted access, bankStb pulses in that same cycle, for one cycle, with bankRegion, bankIntid, bankWrite, bankOffset and bankLen of that request.
- R11: While reset is asserted and after its release with no request, rspValid and bankStb are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | OFS_W (12) | Byte offset of the access |
| reqLen | input | 4 | Access length in bytes |
| reqWdata | input | 64 | Write data, little-endian in the low bytes |
| nrShared | input | SHR_W (10) | Number of implemented shared interrupts |
| bankRdata | input | 64 | Read data from the bank, host order, valid while bankStb is high |
| rspValid | output | 1 | Response cycle for the previous request |
| rspRdata | output | 64 | Read data in bus order, zero if rejected |
| bankStb | output | 1 | One-cycle pulse for an accepted access |
| bankWrite | output | 1 | Direction of the accepted access |
| bankRegion | output | IDX_W (3) | Index of the selected region |
| bankIntid | output | OFS_W+3 (15) | First interrupt number of the access |
| bankOffset | output | OFS_W (12) | Offset of the access |
| bankLen | output | 4 | Length of the access |
| bankWdata | output | 64 | Write data in host order |

## Verification
The assertions assume that nrShared changes only while no response is pending, because the interrupt-limit check compares a registered interrupt number with the present limit. They also assume that bankRdata is driven from the bank's outputs without looping back into the request. The bench changes nrShared only between idle gaps. It drives requests at the falling edge and returns bank data as a pure function of bankOffset. It aims offsets at region bases, region ends and gaps so that range, overlap and alignment boundaries are all reached.

// File: rtl/reg_gate_pkg.sv
package reg_gate_pkg;

  localparam int PRIV_IRQS = 32;

  typedef struct packed {
    logic take;     // a request is being captured
    logic accept;   // the request passed every check
    logic isWrite;  // direction of the request
  } ctlStb_t;

  // allowed-width flag for a byte length; zero when unrecognised
  function automatic logic [2:0] widthFlag(input logic [3:0] len);
    case (len)
      4'd1:    return 3'b001;
      4'd4:    return 3'b010;
      4'd8:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // keep the low len bytes, zero the rest
  function automatic logic [63:0] keepBytes(input logic [63:0] d, input logic [3:0] len);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (i < int'(len)) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // reverse the order of the low len bytes, zero the rest
  function automatic logic [63:0] flipBytes(input logic [63:0] d, input logic [3:0] len);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (i < int'(len)) r[8*(int'(len)-1-i) +: 8] = d[8*i +: 8];
    return r;
  endfunction

endpackage

// File: rtl/reg_gate_match.sv
module reg_gate_match #(
  parameter int NR_REG  = 5,
  parameter int OFS_W   = 12,
  parameter int INTID_W = OFS_W + 3,
  parameter logic [NR_REG*OFS_W-1:0] REG_BASE = '0,
  parameter logic [NR_REG*OFS_W-1:0] REG_SIZE = '0,
  parameter logic [NR_REG*4-1:0]     REG_BPI  = '0
) (
  input  logic [OFS_W-1:0]          reqOffset,
  output logic [NR_REG-1:0]         hitVec,
  output logic [NR_REG*INTID_W-1:0] intidVec
);

  for (genvar gi = 0; gi < NR_REG; gi++) begin : gRegion
    localparam logic [OFS_W-1:0] BASE = REG_BASE[gi*OFS_W +: OFS_W];
    localparam logic [OFS_W-1:0] SIZE = REG_SIZE[gi*OFS_W +: OFS_W];
    localparam logic [3:0]       BPI  = REG_BPI[gi*4 +: 4];

    logic [OFS_W-1:0] relOfs;
    assign relOfs     = reqOffset - BASE;
    assign hitVec[gi] = (reqOffset >= BASE) && (relOfs < SIZE);

    if (BPI == 4'd0) begin : gNoIrq
      assign intidVec[gi*INTID_W +: INTID_W] = '0;
    end else begin : gIrq
      logic [INTID_W-1:0] bitOfs;
      assign bitOfs = {relOfs, 3'b000};
      assign intidVec[gi*INTID_W +: INTID_W] = bitOfs / INTID_W'(BPI);
    end
  end

endmodule

// File: rtl/reg_gate_ctrl.sv
module reg_gate_ctrl
  import reg_gate_pkg::*;
#(
  parameter int NR_REG  = 5,
  parameter int OFS_W   = 12,
  parameter int SHR_W   = 10,
  parameter int INTID_W = OFS_W + 3,
  parameter int IDX_W   = 3,
  parameter logic [NR_REG*3-1:0] REG_WMASK = '0,
  parameter logic [NR_REG*4-1:0] REG_BPI   = '0
) (
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [OFS_W-1:0]          reqOffset,
  input  logic [3:0]                reqLen,
  input  logic [SHR_W-1:0]          nrShared,
  input  logic [NR_REG-1:0]         hitVec,
  input  logic [NR_REG*INTID_W-1:0] intidVec,
  output ctlStb_t                   ctlStb,
  output logic [IDX_W-1:0]          selRegion,
  output logic [INTID_W-1:0]        selIntid
);

  logic               anyHit;
  logic [2:0]         selMask;
  logic [3:0]         selBpi;
  logic               widthOk, alignOk, rangeOk;
  logic [INTID_W-1:0] irqLimit;

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    anyHit    = 1'b0;
    selRegion = '0;
    for (int i = NR_REG - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit    = 1'b1;
        selRegion = IDX_W'(i);
      end
    end
  end

  assign selIntid = intidVec[selRegion*INTID_W +: INTID_W];
  assign selMask  = REG_WMASK[selRegion*3 +: 3];
  assign selBpi   = REG_BPI[selRegion*4 +: 4];

  assign widthOk  = |(widthFlag(reqLen) & selMask);
  assign alignOk  = (reqOffset & (OFS_W'(reqLen) - OFS_W'(1))) == '0;
  assign irqLimit = INTID_W'(PRIV_IRQS) + INTID_W'(nrShared);
  assign rangeOk  = (selBpi == 4'd0) || (selIntid < irqLimit);

  assign ctlStb.take    = reqValid;
  assign ctlStb.accept  = reqValid && anyHit && widthOk && alignOk && rangeOk;
  assign ctlStb.isWrite = reqWrite;

endmodule

// File: rtl/reg_gate_dp.sv
module reg_gate_dp
  import reg_gate_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int INTID_W    = OFS_W + 3,
  parameter int IDX_W      = 3,
  parameter bit HOST_BIG_E = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStb_t            ctlStb,
  input  logic [IDX_W-1:0]   selRegion,
  input  logic [INTID_W-1:0] selIntid,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [3:0]         reqLen,
  input  logic [63:0]        reqWdata,
  input  logic [63:0]        bankRdata,
  output logic               rspValid,
  output logic [63:0]        rspRdata,
  output logic               bankStb,
  output logic               bankWrite,
  output logic [IDX_W-1:0]   bankRegion,
  output logic [INTID_W-1:0] bankIntid,
  output logic [OFS_W-1:0]   bankOffset,
  output logic [3:0]         bankLen,
  output logic [63:0]        bankWdata
);

  logic [63:0] wdataHost;
  logic [63:0] rdataBus;

  // bus order to host order and back are the same byte permutation
  if (HOST_BIG_E) begin : gFlip
    assign wdataHost = flipBytes(reqWdata, reqLen);
    assign rdataBus  = flipBytes(bankRdata, bankLen);
  end else begin : gKeep
    assign wdataHost = keepBytes(reqWdata, reqLen);
    assign rdataBus  = keepBytes(bankRdata, bankLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      bankStb  <= 1'b0;
    end else begin
      rspValid <= ctlStb.take;
      bankStb  <= ctlStb.accept;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankWrite  <= 1'b0;
      bankRegion <= '0;
      bankIntid  <= '0;
      bankOffset <= '0;
      bankLen    <= '0;
      bankWdata  <= '0;
    end else if (ctlStb.take) begin
      bankWrite  <= ctlStb.isWrite;
      bankRegion <= selRegion;
      bankIntid  <= selIntid;
      bankOffset <= reqOffset;
      bankLen    <= reqLen;
      bankWdata  <= wdataHost;
    end
  end

  assign rspRdata = (rspValid && bankStb && !bankWrite) ? rdataBus : '0;

endmodule

// File: rtl/reg_gate.sv
module reg_gate
  import reg_gate_pkg::*;
#(
  parameter int NR_REG     = 5,
  parameter int OFS_W      = 12,
  parameter int SHR_W      = 10,
  parameter bit HOST_BIG_E = 1'b1,
  parameter logic [NR_REG*OFS_W-1:0] REG_BASE  = {12'h000, 12'hC00, 12'h400, 12'h100, 12'h000},
  parameter logic [NR_REG*OFS_W-1:0] REG_SIZE  = {12'h020, 12'h100, 12'h400, 12'h080, 12'h010},
  parameter logic [NR_REG*3-1:0]     REG_WMASK = {3'b100, 3'b010, 3'b011, 3'b010, 3'b011},
  parameter logic [NR_REG*4-1:0]     REG_BPI   = {4'd0, 4'd2, 4'd8, 4'd1, 4'd0},
  localparam int INTID_W = OFS_W + 3,
  localparam int IDX_W   = (NR_REG > 1) ? $clog2(NR_REG) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [3:0]         reqLen,
  input  logic [63:0]        reqWdata,
  input  logic [SHR_W-1:0]   nrShared,
  input  logic [63:0]        bankRdata,
  output logic               rspValid,
  output logic [63:0]        rspRdata,
  output logic               bankStb,
  output logic               bankWrite,
  output logic [IDX_W-1:0]   bankRegion,
  output logic [INTID_W-1:0] bankIntid,
  output logic [OFS_W-1:0]   bankOffset,
  output logic [3:0]         bankLen,
  output logic [63:0]        bankWdata
);

  logic [NR_REG-1:0]         hitVec;
  logic [NR_REG*INTID_W-1:0] intidVec;
  ctlStb_t                   ctlStb;
  logic [IDX_W-1:0]          selRegion;
  logic [INTID_W-1:0]        selIntid;

  reg_gate_match #(
    .NR_REG(NR_REG), .OFS_W(OFS_W), .INTID_W(INTID_W),
    .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE), .REG_BPI(REG_BPI)
  ) uMatch (
    .reqOffset(reqOffset),
    .hitVec(hitVec),
    .intidVec(intidVec)
  );

  reg_gate_ctrl #(
    .NR_REG(NR_REG), .OFS_W(OFS_W), .SHR_W(SHR_W), .INTID_W(INTID_W),
    .IDX_W(IDX_W), .REG_WMASK(REG_WMASK), .REG_BPI(REG_BPI)
  ) uCtrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqOffset(reqOffset),
    .reqLen(reqLen),
    .nrShared(nrShared),
    .hitVec(hitVec),
    .intidVec(intidVec),
    .ctlStb(ctlStb),
    .selRegion(selRegion),
    .selIntid(selIntid)
  );

  reg_gate_dp #(
    .OFS_W(OFS_W), .INTID_W(INTID_W), .IDX_W(IDX_W), .HOST_BIG_E(HOST_BIG_E)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .ctlStb(ctlStb),
    .selRegion(selRegion),
    .selIntid(selIntid),
    .reqOffset(reqOffset),
    .reqLen(reqLen),
    .reqWdata(reqWdata),
    .bankRdata(bankRdata),
    .rspValid(rspValid),
    .rspRdata(rspRdata),
    .bankStb(bankStb),
    .bankWrite(bankWrite),
    .bankRegion(bankRegion),
    .bankIntid(bankIntid),
    .bankOffset(bankOffset),
    .bankLen(bankLen),
    .bankWdata(bankWdata)
  );

endmodule

// File: rtl/reg_gate_chk.sv
module reg_gate_chk #(
  parameter int NR_REG  = 5,
  parameter int OFS_W   = 12,
  parameter int SHR_W   = 10,
  parameter int INTID_W = OFS_W + 3,
  parameter int IDX_W   = 3,
  parameter logic [NR_REG*OFS_W-1:0] REG_BASE = '0,
  parameter logic [NR_REG*OFS_W-1:0] REG_SIZE = '0,
  parameter logic [NR_REG*4-1:0]     REG_BPI  = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [OFS_W-1:0]   reqOffset,
  input logic [3:0]         reqLen,
  input logic [SHR_W-1:0]   nrShared,
  input logic               rspValid,
  input logic [63:0]        rspRdata,
  input logic               bankStb,
  input logic [IDX_W-1:0]   bankRegion,
  input logic [INTID_W-1:0] bankIntid,
  input logic [OFS_W-1:0]   bankOffset
);

  logic               lenKnown;
  logic               misaligned;
  logic [3:0]         stbBpi;
  logic [OFS_W-1:0]   stbBase, stbSize, stbRel;
  logic [INTID_W-1:0] irqLimit;

  assign lenKnown   = (reqLen == 4'd1) || (reqLen == 4'd4) || (reqLen == 4'd8);
  assign misaligned = (reqOffset & (OFS_W'(reqLen) - OFS_W'(1))) != '0;
  assign stbBpi     = REG_BPI[bankRegion*4 +: 4];
  assign stbBase    = REG_BASE[bankRegion*OFS_W +: OFS_W];
  assign stbSize    = REG_SIZE[bankRegion*OFS_W +: OFS_W];
  assign stbRel     = bankOffset - stbBase;
  assign irqLimit   = INTID_W'(32) + INTID_W'(nrShared);

  // R1
  in_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankStb |-> (bankOffset >= stbBase) && (stbRel < stbSize));

  // R3
  bad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !lenKnown) |=> !bankStb);

  // R4
  misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lenKnown && misaligned) |=> !bankStb);

  // R5
  irq_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankStb && stbBpi != 4'd0) |-> (bankIntid < irqLimit));

  // R6
  no_irq_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankStb && stbBpi == 4'd0) |-> (bankIntid == '0));

  // R8
  reject_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !bankStb) |-> (rspRdata == '0));

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !bankStb));

endmodule

bind reg_gate reg_gate_chk #(
  .NR_REG(NR_REG), .OFS_W(OFS_W), .SHR_W(SHR_W), .INTID_W(INTID_W), .IDX_W(IDX_W),
  .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE), .REG_BPI(REG_BPI)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
  .reqLen(reqLen), .nrShared(nrShared), .rspValid(rspValid), .rspRdata(rspRdata),
  .bankStb(bankStb), .bankRegion(bankRegion), .bankIntid(bankIntid),
  .bankOffset(bankOffset)
);

// File: tb/tb_reg_gate.sv
module tb_reg_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqOffset = '0;
  logic [3:0]  reqLen = '0;
  logic [63:0] reqWdata = '0;
  logic [9:0]  nrShared = '0;
  logic [63:0] bankRdata;
  logic        rspValid;
  logic [63:0] rspRdata;
  logic        bankStb;
  logic        bankWrite;
  logic [2:0]  bankRegion;
  logic [14:0] bankIntid;
  logic [11:0] bankOffset;
  logic [3:0]  bankLen;
  logic [63:0] bankWdata;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  // bank model: read data is a fixed function of the offset
  function automatic logic [63:0] bankPattern(input logic [11:0] ofs);
    return 64'hF0E1_D2C3_B4A5_9687 ^ {52'h0, ofs};
  endfunction
  assign bankRdata = bankPattern(bankOffset);

  reg_gate dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqLen(reqLen), .reqWdata(reqWdata),
    .nrShared(nrShared), .bankRdata(bankRdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .bankStb(bankStb), .bankWrite(bankWrite),
    .bankRegion(bankRegion), .bankIntid(bankIntid), .bankOffset(bankOffset),
    .bankLen(bankLen), .bankWdata(bankWdata)
  );

  // region table as stated in the requirements
  localparam int TB_BASE [5] = '{12'h000, 12'h100, 12'h400, 12'hC00, 12'h000};
  localparam int TB_SIZE [5] = '{12'h010, 12'h080, 12'h400, 12'h100, 12'h020};
  localparam int TB_MASK [5] = '{3, 2, 3, 2, 4};
  localparam int TB_BPI  [5] = '{0, 1, 8, 2, 0};

  function automatic logic [63:0] revLow(input logic [63:0] d, input int len);
    logic [63:0] r = '0;
    for (int k = 0; k < len; k++) r[8*(len-1-k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic void refModel(input int ofs, input int len, input int nrs,
                                   output bit acc, output int rg, output int irq);
    int flag;
    acc = 0; rg = -1; irq = 0;
    for (int k = 0; k < 5; k++)
      if (rg < 0 && ofs >= TB_BASE[k] && ofs < TB_BASE[k] + TB_SIZE[k]) rg = k;
    if (rg < 0) return;
    flag = (len == 1) ? 1 : (len == 4) ? 2 : (len == 8) ? 4 : 0;
    if ((flag & TB_MASK[rg]) == 0) return;
    if (ofs % len != 0) return;
    if (TB_BPI[rg] != 0) begin
      irq = ((ofs - TB_BASE[rg]) * 8) / TB_BPI[rg];
      if (irq >= 32 + nrs) return;
    end
    acc = 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int ofs, input int len,
                        input logic [63:0] wd, input string req);
    bit acc; int rg; int irq;
    logic [63:0] expR;
    refModel(ofs, len, int'(nrShared), acc, rg, irq);
    @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqOffset = 12'(ofs);
    reqLen    = 4'(len);
    reqWdata  = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R10", "rspValid", 64'(rspValid), 64'd1);
    check(bankStb == acc, req, "bankStb", 64'(bankStb), 64'(acc));
    if (acc) begin
      check(bankRegion == 3'(rg), req, "bankRegion", 64'(bankRegion), 64'(rg));
      check(bankIntid == 15'(irq), req, "bankIntid", 64'(bankIntid), 64'(irq));
      check(bankWrite == wr && bankOffset == 12'(ofs) && bankLen == 4'(len), "R10",
            "bank fields", {bankWrite, bankOffset, bankLen}, {wr, 12'(ofs), 4'(len)});
      if (wr) check(bankWdata == revLow(wd, len), "R7", "bankWdata", bankWdata, revLow(wd, len));
    end
    if (!wr) begin
      expR = acc ? revLow(bankPattern(12'(ofs)), len) : 64'h0;
      check(rspRdata == expR, acc ? "R7" : "R8", "rspRdata", rspRdata, expR);
    end
    @(negedge clk);
    check(bankStb == 1'b0 && rspValid == 1'b0, "R10", "one-cycle pulse",
          {bankStb, rspValid}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0 && bankStb == 1'b0, "R11", "during reset", {rspValid, bankStb}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(rspValid == 1'b0 && bankStb == 1'b0, "R11", "after reset", {rspValid, bankStb}, 0);

    nrShared = 10'd64;  // limit 96
    access(0, 12'h004, 4, 0, "R6");                       // region 0, no irq check
    access(0, 12'h010, 8, 0, "R2");                       // only region 4 matches
    access(0, 12'h008, 8, 0, "R2");                       // region 0 wins and lacks 8-byte
    access(1, 12'h104, 4, 64'h1122_3344_5566_7788, "R5"); // irq 32
    access(1, 12'h10C, 4, 64'hDEAD_BEEF, "R9");           // irq 96 rejected write
    access(0, 12'h108, 4, 0, "R5");                       // irq 64
    access(0, 12'h102, 4, 0, "R4");                       // misaligned
    access(0, 12'h100, 2, 0, "R3");                       // unrecognised length
    access(0, 12'h101, 3, 0, "R3");
    access(0, 12'h45F, 1, 0, "R5");                       // irq 95, last legal
    access(0, 12'h460, 1, 0, "R5");                       // irq 96
    access(0, 12'h080, 4, 0, "R1");                       // gap
    access(0, 12'h01C, 4, 0, "R3");                       // region 4 allows only 8
    access(1, 12'h400, 1, 64'hFFFF_FFFF_FFFF_FFA5, "R7"); // only low byte kept
    access(1, 12'h018, 8, 64'h0102_0304_0506_0708, "R7");
    access(0, 12'hC08, 4, 0, "R5");                       // bpi 2: irq 32
    @(negedge clk);
    nrShared = 10'd992;  // limit 1024
    @(negedge clk);
    access(0, 12'h17C, 4, 0, "R1");                       // last word of region 1
    access(0, 12'h180, 4, 0, "R1");                       // one past its end
    access(0, 12'hCFC, 4, 0, "R5");
    access(0, 12'hD00, 4, 0, "R1");

    for (int phase = 0; phase < 3; phase++) begin
      @(negedge clk);
      nrShared = (phase == 0) ? 10'd0 : (phase == 1) ? 10'd200 : 10'd1023;
      @(negedge clk);
      for (int n = 0; n < 1500; n++) begin
        int ofs; int len; int pick;
        pick = int'($urandom_range(0, 3));
        if (pick == 0) ofs = int'($urandom_range(0, 4095));
        else begin
          int rg = int'($urandom_range(0, 4));
          ofs = (TB_BASE[rg] + TB_SIZE[rg] - 16 + int'($urandom_range(0, 31))) & 12'hFFF;
          if (pick == 1) ofs = (TB_BASE[rg] + int'($urandom_range(0, 63))) & 12'hFFF;
        end
        case ($urandom_range(0, 5))
          0: len = 1; 1: len = 4; 2: len = 8; 3: len = 4; 4: len = 2; default: len = 3;
        endcase
        access($urandom_range(0, 1) == 1, ofs, len, {$urandom, $urandom},
               "R1 R2 R3 R4 R5");
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule